// File: doc/BRIEF.md
# Adaptive line-comb Y/C separator

This block splits a stream of 8-bit composite video samples, taken at four times the colour subcarrier, into a luminance stream and a chroma stream. For every sample it builds two chroma estimates. The first is a vertical line comb over the lines directly above and below. The second is a horizontal band-pass filter that takes the samples two positions to either side. Luminance is the input sample minus whichever chroma estimate is used.

In adaptive mode the block measures how far the upper and lower lines disagree around the current position. When they agree closely, it uses the comb. Otherwise it falls back to the band-pass estimate, so vertical edges do not smear chroma across lines. The spacing between the three lines is one line for NTSC and two lines for the PAL family. This keeps the subcarrier phase inverted between the outer taps and the centre. A band-pass-only mode and a through mode are also provided.

The line delays are circular RAM buffers held inside the block. Every mode has the same fixed latency, so the outputs stay aligned with the input regardless of mode.

Top module: `ycsep_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pipeline state is cleared, so on the first clock after release `luma_out` and `chroma_out` are both 0.
- R2: The result for input sample x[j] appears exactly L+20 clocks after x[j] is presented. L is `LINE_NTSC` when `tv_std` is 00 and 2*`LINE_PAL` otherwise. The result depends only on x[j-L-2..j-L+2], x[j-2..j+2] and x[j+L-2..j+L+2].
- R3: When `sep_mode` is 11 (through), both `luma_out` and `chroma_out` carry the bits of x[j] unchanged.
- R4: When `sep_mode` is 10 (band-pass), chroma c = floor((2*x[j] - x[j-2] - x[j+2]) / 4) and luma = x[j] - c.
- R5: When `sep_mode` is 00 (adaptive), the metric is M = sum over h in {-1,0,1} of |x[j-L+h] - x[j+L+h]|. When M < `comb_thresh`, chroma c = floor((2*x[j] - x[j-L] - x[j+L]) / 4) and luma = x[j] - c.
- R6: In adaptive mode, when M >= `comb_thresh` (including M equal to it), the band-pass formulas of R4 apply. A threshold of 0 therefore never selects the comb.
- R7: `chroma_out` is two's complement, clipped to [-128, 127]. `luma_out` is unsigned, clipped to [0, 255]. Alternating full-scale lines (0 and 255) in adaptive comb give chroma 127 or -128, each with luma 128.
- R8: Standard codes 01, 10 and 11 behave identically and all use the two-line spacing. Code 00 uses the one-line spacing.
- R9: `sep_mode` 01 behaves exactly like 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the subcarrier |
| rst_n | input | 1 | Synchronous reset, active low |
| cvbs_in | input | 8 | Composite sample, unsigned |
| sep_mode | input | 2 | 00/01 adaptive, 10 band-pass only, 11 through |
| tv_std | input | 2 | 00 NTSC, 01 PAL, 10 M-PAL, 11 N-PAL; change only while in reset |
| comb_thresh | input | 10 | Comb is used when the vertical metric is below this value |
| luma_out | output | 8 | Separated luminance, unsigned |
| chroma_out | output | 8 | Separated chroma, two's complement |

## Verification
The hardest situation to reach from the ports is the decision boundary: a pixel whose vertical metric equals the threshold exactly, with every RAM tap already holding samples written since reset. The stimulus builds the lines from a per-line step of 10 plus a horizontal pattern of period four. Because the line spacing is a multiple of two lines of that period, the metric is exactly 60 at every checked pixel. Runs at thresholds 60 and 61 then land on each side of the boundary. The same sweep covers all four standard codes and all four mode codes. Lines alternating between 0 and 255 drive the chroma result to both ends of its range.

// File: rtl/ycsep_pkg.sv
// Shared widths, mode/standard encodings and arithmetic helpers for the
// Y/C separator. Assumes unsigned composite samples of SMP_W bits.
package ycsep_pkg;

    parameter int unsigned SMP_W = 8;
    localparam int unsigned ACC_W = SMP_W + 3;
    localparam int unsigned MET_W = SMP_W + 2;

    typedef logic [SMP_W-1:0]        smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [MET_W-1:0]        met_t;

    typedef enum logic [1:0] {
        SEP_ADAPT     = 2'b00,
        SEP_ADAPT_ALT = 2'b01,
        SEP_BAND      = 2'b10,
        SEP_PASS      = 2'b11
    } sep_mode_e;

    typedef enum logic [1:0] {
        STD_NTSC = 2'b00,
        STD_PAL  = 2'b01,
        STD_PALM = 2'b10,
        STD_PALN = 2'b11
    } tv_std_e;

    localparam acc_t C_MAX = acc_t'((1 << (SMP_W - 1)) - 1);
    localparam acc_t C_MIN = acc_t'(-(1 << (SMP_W - 1)));
    localparam acc_t Y_MAX = acc_t'((1 << SMP_W) - 1);

    // Magnitude of the difference of two unsigned samples.
    function automatic smp_t abs_diff(input smp_t a, input smp_t b);
        return (a > b) ? smp_t'(a - b) : smp_t'(b - a);
    endfunction

    // floor((2*ctr - p - q) / 4) as a signed value.
    function automatic acc_t quarter_sep(input smp_t ctr, input smp_t p, input smp_t q);
        acc_t s;
        s = $signed({2'b00, ctr, 1'b0}) - $signed({3'b000, p}) - $signed({3'b000, q});
        return s >>> 2;
    endfunction

    // Clip a signed value into the signed sample range.
    function automatic smp_t clip_signed(input acc_t v);
        acc_t t;
        t = (v > C_MAX) ? C_MAX : ((v < C_MIN) ? C_MIN : v);
        return t[SMP_W-1:0];
    endfunction

    // Clip a signed value into the unsigned sample range.
    function automatic smp_t clip_unsigned(input acc_t v);
        acc_t t;
        t = (v < 0) ? acc_t'(0) : ((v > Y_MAX) ? Y_MAX : v);
        return t[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/ycsep_line_delay.sv
// Line delay built as a circular RAM with one pointer: each cycle the slot
// under the pointer is read into a register and overwritten with the new
// sample. With 'slots' = L-1 locations in use, dout lags din by exactly L
// clocks. Assumes 'slots' only changes while rst_n is low and 2 <= slots+1.
module ycsep_line_delay
    import ycsep_pkg::*;
#(
    parameter int unsigned DEPTH = 2269,
    parameter int unsigned AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] slots,
    input  smp_t          din,
    output smp_t          dout
);

    smp_t          store [DEPTH];
    logic [AW-1:0] ptr;

    // Overwrite the slot under the pointer with the incoming sample.
    always_ff @(posedge clk) begin : p_store
        store[ptr] <= din;
    end

    // Fetch the oldest sample and advance the pointer around the used slots.
    always_ff @(posedge clk) begin : p_fetch
        if (!rst_n) begin
            dout <= '0;
            ptr  <= '0;
        end else begin
            dout <= store[ptr];
            ptr  <= (ptr >= slots - AW'(1)) ? '0 : ptr + AW'(1);
        end
    end

    AST_PTR_WITHIN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < slots);  // R2

endmodule

// File: rtl/ycsep_hwin.sv
// Horizontal tap window: a shift register of LEAD+TAPS stages whose last
// TAPS stages are exposed. taps[t] is din delayed by LEAD+t+1 clocks.
module ycsep_hwin
    import ycsep_pkg::*;
#(
    parameter int unsigned LEAD = 0,
    parameter int unsigned TAPS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  smp_t din,
    output smp_t taps [TAPS]
);

    localparam int unsigned LEN = LEAD + TAPS;

    smp_t chain [LEN];

    // First stage captures the incoming sample.
    always_ff @(posedge clk) begin : p_head
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar k = 1; k < LEN; k++) begin : g_stage
        // Each later stage shifts its predecessor by one clock.
        always_ff @(posedge clk) begin : p_shift
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= chain[k-1];
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign taps[t] = chain[LEAD + t];
    end

endmodule

// File: rtl/ycsep_sep_core.sv
// Separation arithmetic. Stage A computes the band-pass and comb chroma
// estimates and the vertical disagreement metric. Stage B chooses per mode
// and forms luma. Assumes all windows are aligned on the centre sample:
// ctr_win[2] is the centre, ctr_win[0]/[4] are two samples later/earlier,
// and up_win[1]/dn_win[1] sit vertically above/below the centre.
module ycsep_sep_core
    import ycsep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sep_mode_e mode,
    input  met_t      thresh,
    input  smp_t      ctr_win [5],
    input  smp_t      up_win  [3],
    input  smp_t      dn_win  [3],
    output smp_t      y_o,
    output smp_t      c_o
);

    met_t met_now;
    smp_t cb_now, cc_now;
    smp_t m_s4, cb_s4, cc_s4;
    met_t met_s4;
    smp_t c_sel, y_sel;

    // Stage A combinational: both chroma estimates and the three-tap metric.
    always_comb begin : p_estimate
        met_now = met_t'(abs_diff(up_win[0], dn_win[0]))
                + met_t'(abs_diff(up_win[1], dn_win[1]))
                + met_t'(abs_diff(up_win[2], dn_win[2]));
        cb_now  = clip_signed(quarter_sep(ctr_win[2], ctr_win[0], ctr_win[4]));
        cc_now  = clip_signed(quarter_sep(ctr_win[2], up_win[1], dn_win[1]));
    end

    // Stage A register: hold centre, estimates and metric.
    always_ff @(posedge clk) begin : p_stage_a
        if (!rst_n) begin
            m_s4   <= '0;
            cb_s4  <= '0;
            cc_s4  <= '0;
            met_s4 <= '0;
        end else begin
            m_s4   <= ctr_win[2];
            cb_s4  <= cb_now;
            cc_s4  <= cc_now;
            met_s4 <= met_now;
        end
    end

    // Stage B combinational: mode selection and luma subtraction.
    always_comb begin : p_select
        unique case (mode)
            SEP_PASS: c_sel = m_s4;
            SEP_BAND: c_sel = cb_s4;
            default:  c_sel = (met_s4 < thresh) ? cc_s4 : cb_s4;
        endcase
        if (mode == SEP_PASS)
            y_sel = m_s4;
        else
            y_sel = clip_unsigned($signed({3'b000, m_s4}) - acc_t'($signed(c_sel)));
    end

    // Stage B register: the separated pair.
    always_ff @(posedge clk) begin : p_stage_b
        if (!rst_n) begin
            y_o <= '0;
            c_o <= '0;
        end else begin
            y_o <= y_sel;
            c_o <= c_sel;
        end
    end

    AST_FLAT_BAND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_win[0] == ctr_win[2] && ctr_win[4] == ctr_win[2]) |=> cb_s4 == '0);  // R4

    AST_BAND_MODE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEP_BAND) |=> c_o == $past(cb_s4));  // R4

    AST_PASS_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEP_PASS) |=> (y_o == $past(m_s4) && c_o == $past(m_s4)));  // R3

    AST_COMB_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0 && met_s4 < thresh) |=> c_o == $past(cc_s4));  // R5

    AST_BAND_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0 && met_s4 >= thresh) |=> c_o == $past(cb_s4));  // R6

endmodule

// File: rtl/ycsep_out_pad.sv
// Pure delay of STAGES registers that brings total latency to its fixed value.
module ycsep_out_pad #(
    parameter int unsigned STAGES = 14,
    parameter int unsigned W      = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (STAGES == 0) begin : g_none
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] pipe [STAGES];

        // First pad stage takes the separated pair.
        always_ff @(posedge clk) begin : p_first
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= d;
        end

        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            // Each pad stage shifts by one clock.
            always_ff @(posedge clk) begin : p_shift
                if (!rst_n) pipe[k] <= '0;
                else        pipe[k] <= pipe[k-1];
            end
        end

        assign q = pipe[STAGES-1];
    end

endmodule

// File: rtl/ycsep_top.sv
// Adaptive line-comb Y/C separator. One input register feeds two cascaded
// line delays, so three taps see the lines below, at and above the centre.
// Three horizontal windows align them and the core separates the centre
// sample. A pad delay makes the latency L + LOGIC_LAT in every mode.
// Assumes tv_std is changed only while rst_n is low.
module ycsep_top
    import ycsep_pkg::*;
#(
    parameter int unsigned LINE_NTSC = 910,
    parameter int unsigned LINE_PAL  = 1135,
    parameter int unsigned LOGIC_LAT = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SMP_W-1:0]      cvbs_in,
    input  logic [1:0]            sep_mode,
    input  logic [1:0]            tv_std,
    input  logic [MET_W-1:0]      comb_thresh,
    output logic [SMP_W-1:0]      luma_out,
    output logic [SMP_W-1:0]      chroma_out
);

    localparam int unsigned CORE_REGS  = 6;
    localparam int unsigned PAD_STAGES = LOGIC_LAT - CORE_REGS;
    localparam int unsigned SPAN_PAL   = 2 * LINE_PAL;
    localparam int unsigned SPAN_MAX   = (LINE_NTSC > SPAN_PAL) ? LINE_NTSC : SPAN_PAL;
    localparam int unsigned DEPTH      = SPAN_MAX - 1;
    localparam int unsigned AW         = $clog2(DEPTH + 1);

    smp_t          near_tap, mid_tap, far_tap;
    logic [AW-1:0] slots;
    smp_t          ctr_win [5];
    smp_t          up_win  [3];
    smp_t          dn_win  [3];
    smp_t          y_core, c_core;

    assign slots = (tv_std_e'(tv_std) == STD_NTSC) ? AW'(LINE_NTSC - 1) : AW'(SPAN_PAL - 1);

    // Input register: the newest line tap.
    always_ff @(posedge clk) begin : p_input
        if (!rst_n) near_tap <= '0;
        else        near_tap <= cvbs_in;
    end

    ycsep_line_delay #(.DEPTH(DEPTH), .AW(AW)) dly_mid_i (
        .clk(clk), .rst_n(rst_n), .slots(slots), .din(near_tap), .dout(mid_tap)
    );

    ycsep_line_delay #(.DEPTH(DEPTH), .AW(AW)) dly_far_i (
        .clk(clk), .rst_n(rst_n), .slots(slots), .din(mid_tap), .dout(far_tap)
    );

    ycsep_hwin #(.LEAD(0), .TAPS(5)) win_ctr_i (
        .clk(clk), .rst_n(rst_n), .din(mid_tap), .taps(ctr_win)
    );

    ycsep_hwin #(.LEAD(1), .TAPS(3)) win_up_i (
        .clk(clk), .rst_n(rst_n), .din(far_tap), .taps(up_win)
    );

    ycsep_hwin #(.LEAD(1), .TAPS(3)) win_dn_i (
        .clk(clk), .rst_n(rst_n), .din(near_tap), .taps(dn_win)
    );

    ycsep_sep_core core_i (
        .clk(clk), .rst_n(rst_n), .mode(sep_mode_e'(sep_mode)), .thresh(comb_thresh),
        .ctr_win(ctr_win), .up_win(up_win), .dn_win(dn_win),
        .y_o(y_core), .c_o(c_core)
    );

    ycsep_out_pad #(.STAGES(PAD_STAGES), .W(2 * SMP_W)) pad_i (
        .clk(clk), .rst_n(rst_n), .d({y_core, c_core}), .q({luma_out, chroma_out})
    );

    AST_RESET_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (luma_out == '0 && chroma_out == '0));  // R1

endmodule

// File: tb/ycsep_top_tb_top.sv
// Sweeps every standard code, every mode code, four thresholds and four
// sample patterns on short lines. Each checked output is compared with the
// value computed arithmetically from the requirement formulas.
module ycsep_top_tb_top;

    localparam int LN = 6;
    localparam int LP = 5;
    localparam int LL = 20;
    localparam int NS = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cvbs_in = '0;
    logic [1:0] sep_mode = '0;
    logic [1:0] tv_std = '0;
    logic [9:0] comb_thresh = '0;
    logic [7:0] luma_out, chroma_out;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    int xs [NS];

    always #2 clk = ~clk;

    ycsep_top #(.LINE_NTSC(LN), .LINE_PAL(LP), .LOGIC_LAT(LL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cvbs_in(cvbs_in), .sep_mode(sep_mode),
        .tv_std(tv_std), .comb_thresh(comb_thresh),
        .luma_out(luma_out), .chroma_out(chroma_out)
    );

    function automatic int clip(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int quarter(int c, int p, int q);
        return (2 * c - p - q) >>> 2;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int pattern_val(int pat, int k, int L);
        case (pat)
            0: return $urandom_range(0, 255);
            1: return (k % 4) * 60;
            2: return ((k / L) % 2) ? 255 : 0;
            default: return 60 + 10 * (k / L) + ((k % 4 == 1) ? 20 : ((k % 4 == 3) ? -20 : 0));
        endcase
    endfunction

    task automatic run(int std, int md, int thr, int pat);
        int L, lat;
        L   = (std == 0) ? LN : 2 * LP;  // R2 R8 spacing per standard code
        lat = L + LL;
        for (int k = 0; k < NS; k++) xs[k] = pattern_val(pat, k, L);
        @(negedge clk);
        rst_n = 1'b0; tv_std = 2'(std); sep_mode = 2'(md);
        comb_thresh = 10'(thr); cvbs_in = '0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NS + lat; i++) begin
            if (i != 0) @(negedge clk);
            if (i == 0) begin
                vecs++;  // R1 reset state
                if (luma_out !== 8'd0 || chroma_out !== 8'd0) begin
                    errs++;
                    $display("FAIL R1 after reset: luma %0d chroma %0d, expected 0 0",
                             luma_out, chroma_out);
                end
                rst_n = 1'b1;
            end
            begin
                int j, ey, ec, met, ay, ac;
                string tag;
                j = i - lat;
                if (j >= L + 2 && j + L + 2 <= NS - 1) begin
                    met = 0;
                    for (int h = -1; h <= 1; h++) met += iabs(xs[j-L+h] - xs[j+L+h]);
                    if (md == 3) begin
                        ey = xs[j]; ec = xs[j]; tag = "R3";
                        if (ec > 127) ec = ec - 256;  // bits compared as signed
                    end else begin
                        if (md != 2 && met < thr) begin
                            ec = clip(quarter(xs[j], xs[j-L], xs[j+L]), -128, 127);
                            tag = "R5";
                        end else begin
                            ec = clip(quarter(xs[j], xs[j-2], xs[j+2]), -128, 127);
                            tag = (md == 2) ? "R4" : ((met == thr) ? "R6 boundary" : "R6");
                        end
                        ey = clip(xs[j] - ec, 0, 255);
                        if (ec == 127 || ec == -128) tag = {tag, " R7"};
                    end
                    if (md == 1) tag = {tag, " R9"};
                    if (std != 0) tag = {tag, " R8"};
                    tag = {tag, " R2"};
                    ay = int'(luma_out);
                    ac = int'($signed(chroma_out));
                    vecs++;
                    if (ay != ey || ac != ec) begin
                        errs++;
                        $display("FAIL %s std=%0d mode=%0d thr=%0d pat=%0d j=%0d: luma %0d exp %0d, chroma %0d exp %0d",
                                 tag, std, md, thr, pat, j, ay, ey, ac, ec);
                    end
                end
            end
            cvbs_in = (i < NS) ? 8'(xs[i]) : 8'd0;
        end
    endtask

    initial begin : main
        int modes [4];
        int thrs [4];
        modes = '{0, 2, 3, 1};
        thrs  = '{0, 60, 61, 1023};
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
                for (int p = 0; p < 4; p++)
                    for (int t = 0; t < 4; t++)
                        run(s, modes[m], thrs[t], p);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R2 watchdog expired before the sweep ended");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule